// File: doc/BRIEF.md
# Fine-Grained Multithread Issue Selector

This block is the thread-select stage of a single-issue, in-order core that interleaves several hardware threads, four by default. In every cycle it names one thread whose next instruction may issue, and it moves on to a different thread in the next cycle. The choice rotates round-robin: the search for the next thread begins at the thread after the one that issued last. The selection is combinational from registered per-thread state, so `selValid` and `selId` are valid throughout the cycle in which the chosen instruction issues.

A thread is passed over while it waits on either of two things. The first is an outstanding cache miss, which starts with a pulse on its `missSet` bit and ends with a pulse on its `fillDone` bit. The second is a short pipeline shadow. When the issuing instruction is a load or a branch, the issue stage raises `selLong` in that same cycle, and the issuing thread is then unavailable for a fixed number of cycles. That latency is hidden only by the other threads. If every thread is stalled, no instruction issues and `selValid` is low.

Top module: `mtsel_top`

## Requirements
- R1: Out of reset, no thread has a miss pending and every shadow counter is zero. The first selection is thread 0, because the last-issued pointer resets to the highest thread number.
- R2: The search for a ready thread starts at the thread after the last issued one and wraps modulo THREADS. With all threads ready, the issued ids therefore run 0,1,2,3,0 and so on.
- R3: A pulse on `missSet[t]` keeps thread t from being selected from the next cycle on, for as long as no `fillDone[t]` pulse has arrived.
- R4: If `selValid` and `selLong` are both high in a cycle, the selected thread cannot be selected in the next SHADOW_CYCLES (3) cycles. It becomes eligible again in the cycle after that.
- R5: `selValid` is low only when every thread is stalled by a pending miss or a running shadow. Otherwise one ready thread is selected.
- R6: When exactly one thread is ready, that thread is selected in consecutive cycles.
- R7: After a pulse on `fillDone[t]`, thread t is eligible again in the next cycle.
- R8: If `missSet[t]` and `fillDone[t]` pulse in the same cycle, the miss wins and thread t stays stalled.
- R9: `selLong` has no effect in a cycle where `selValid` is low. No thread enters a shadow as a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| missSet | input | THREADS | One bit per thread; a pulse marks a new cache miss for that thread |
| fillDone | input | THREADS | One bit per thread; a pulse ends that thread's pending miss |
| selLong | input | 1 | High when the instruction issuing this cycle is a load or a branch |
| selValid | output | 1 | A thread is selected this cycle |
| selId | output | $clog2(THREADS) | Id of the selected thread |

## Verification
The bench builds the block with its defaults: four threads and a three-cycle shadow. At that size the whole per-thread state (a miss flag and a two-bit counter per thread, plus the rotation pointer) is small. A long pseudo-random sweep, together with directed sequences, therefore reaches every rotation position combined with every mix of missed, shadowed and ready threads. The directed sequences force the rare cases: a single ready thread repeating, all four threads stalled with `selLong` toggling, a miss and a fill arriving together, and a thread coming back exactly on the fourth cycle after a long operation.

// File: rtl/mtsel_pkg.sv
package mtsel_pkg;

  // Strobes the control half hands to the per-thread state half.
  typedef struct packed {
    logic issueFire;    // a thread issues this cycle
    logic shadowStart;  // the issuing instruction opens a shadow
  } issue_strobe_t;

  // Width of a down-counter that must hold the value n (at least one bit).
  function automatic int unsigned ctrWidth(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/mtsel_dp.sv
module mtsel_dp #(
  parameter int unsigned THREADS       = 4,
  parameter int unsigned SHADOW_CYCLES = 3,
  parameter int unsigned ID_W          = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [THREADS-1:0]          missSet,
  input  logic [THREADS-1:0]          fillDone,
  input  mtsel_pkg::issue_strobe_t    strobe,
  input  logic [ID_W-1:0]             selId,
  output logic [THREADS-1:0]          readyMask
);

  localparam int unsigned CNT_W = mtsel_pkg::ctrWidth(SHADOW_CYCLES);
  localparam logic [CNT_W-1:0] SHADOW_LOAD = CNT_W'(SHADOW_CYCLES);

  for (genvar t = 0; t < THREADS; t++) begin : g_thread
    logic             missPending;
    logic [CNT_W-1:0] shadowLeft;
    logic             hitThis;

    assign hitThis = strobe.issueFire && strobe.shadowStart && (selId == ID_W'(t));

    // A new miss takes priority over a fill that lands in the same cycle.
    always_ff @(posedge clk) begin
      if (!rstN)            missPending <= 1'b0;
      else if (missSet[t])  missPending <= 1'b1;
      else if (fillDone[t]) missPending <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                   shadowLeft <= '0;
      else if (hitThis)            shadowLeft <= SHADOW_LOAD;
      else if (shadowLeft != '0)   shadowLeft <= shadowLeft - 1'b1;
    end

    assign readyMask[t] = !missPending && (shadowLeft == '0);
  end

endmodule

// File: rtl/mtsel_ctrl.sv
module mtsel_ctrl #(
  parameter int unsigned THREADS = 4,
  parameter int unsigned ID_W    = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [THREADS-1:0]       readyMask,
  input  logic                     selLong,
  output logic                     selValid,
  output logic [ID_W-1:0]          selId,
  output mtsel_pkg::issue_strobe_t strobe
);

  localparam logic [ID_W-1:0] LAST_INIT = ID_W'(THREADS - 1);
  localparam logic [ID_W:0]   WRAP_AT   = (ID_W+1)'(THREADS);

  logic [ID_W-1:0] lastId;
  logic [ID_W:0]   cand;
  logic            found;
  logic [ID_W-1:0] pick;

  // Circular scan beginning one past the last issuer; the last issuer
  // itself is examined last, so a lone ready thread may repeat.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    cand  = '0;
    for (int off = 1; off <= int'(THREADS); off++) begin
      cand = {1'b0, lastId} + (ID_W+1)'(off);
      if (cand >= WRAP_AT) cand = cand - WRAP_AT;
      if (!found && readyMask[cand[ID_W-1:0]]) begin
        found = 1'b1;
        pick  = cand[ID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      lastId <= LAST_INIT;
    else if (found) lastId <= pick;
  end

  assign selValid           = found;
  assign selId              = pick;
  assign strobe.issueFire   = found;
  assign strobe.shadowStart = found && selLong;

endmodule

// File: rtl/mtsel_top.sv
module mtsel_top #(
  parameter int unsigned THREADS       = 4,
  parameter int unsigned SHADOW_CYCLES = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [THREADS-1:0]          missSet,
  input  logic [THREADS-1:0]          fillDone,
  input  logic                        selLong,
  output logic                        selValid,
  output logic [$clog2(THREADS)-1:0]  selId
);

  localparam int unsigned ID_W = $clog2(THREADS);

  logic [THREADS-1:0]       readyMask;
  mtsel_pkg::issue_strobe_t strobe;

  mtsel_ctrl #(.THREADS(THREADS), .ID_W(ID_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .readyMask (readyMask),
    .selLong   (selLong),
    .selValid  (selValid),
    .selId     (selId),
    .strobe    (strobe)
  );

  mtsel_dp #(.THREADS(THREADS), .SHADOW_CYCLES(SHADOW_CYCLES), .ID_W(ID_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .missSet   (missSet),
    .fillDone  (fillDone),
    .strobe    (strobe),
    .selId     (selId),
    .readyMask (readyMask)
  );

endmodule

// File: rtl/mtsel_checker.sv
module mtsel_checker #(
  parameter int unsigned THREADS       = 4,
  parameter int unsigned SHADOW_CYCLES = 3,
  parameter int unsigned ID_W          = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [THREADS-1:0] missSet,
  input logic [THREADS-1:0] fillDone,
  input logic               selLong,
  input logic               selValid,
  input logic [ID_W-1:0]    selId
);

  logic [THREADS-1:0] pendMiss;
  logic [THREADS-1:0] inShadow;
  logic [THREADS-1:0] eligible;
  int unsigned        left [THREADS];
  logic               armed;

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_obs
    always_ff @(posedge clk) begin
      if (!rstN)            pendMiss[t] <= 1'b0;
      else if (missSet[t])  pendMiss[t] <= 1'b1;
      else if (fillDone[t]) pendMiss[t] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN)                                         left[t] <= 0;
      else if (selValid && selLong && selId == ID_W'(t)) left[t] <= SHADOW_CYCLES;
      else if (left[t] != 0)                             left[t] <= left[t] - 1;
    end
    assign inShadow[t] = (left[t] != 0);
    assign eligible[t] = !pendMiss[t] && !inShadow[t];
  end

  AST_NO_MISSED_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> !pendMiss[selId]);                                          // R3
  AST_NO_SHADOW_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> !inShadow[selId]);                                          // R4
  AST_IDLE_ONLY_ALL_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    !selValid |-> (eligible == '0));                                         // R5
  AST_ISSUE_WHEN_ANY_READY: assert property (@(posedge clk) disable iff (!rstN)
    (eligible != '0) |-> selValid);                                          // R5
  AST_REPEAT_ONLY_SOLE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && selValid && $past(selValid) && selId == $past(selId))
      |-> ($countones(eligible) == 1));                                      // R6

endmodule

bind mtsel_top mtsel_checker #(
  .THREADS(THREADS), .SHADOW_CYCLES(SHADOW_CYCLES), .ID_W($clog2(THREADS))
) u_chk (
  .clk(clk), .rstN(rstN), .missSet(missSet), .fillDone(fillDone),
  .selLong(selLong), .selValid(selValid), .selId(selId)
);

// File: tb/mtsel_top_bench.sv
`timescale 1ns/1ps
module mtsel_top_bench;

  localparam int NT = 4;
  localparam int SH = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NT-1:0] missSet;
  logic [NT-1:0] fillDone;
  logic          selLong;
  logic          selValid;
  logic [1:0]    selId;

  int checks = 0;
  int errors = 0;

  // Bench-side expected state
  int mCnt [NT];
  bit mMiss [NT];
  int mLast;

  always #2.5 clk = ~clk;

  mtsel_top #(.THREADS(NT), .SHADOW_CYCLES(SH)) u_mtsel_top (
    .clk(clk), .rstN(rstN), .missSet(missSet), .fillDone(fillDone),
    .selLong(selLong), .selValid(selValid), .selId(selId)
  );

  function automatic void modelSel(output bit v, output int id);
    v = 0; id = 0;
    for (int off = 1; off <= NT; off++) begin
      int idx;
      idx = (mLast + off) % NT;
      if (!v && !mMiss[idx] && mCnt[idx] == 0) begin
        v = 1; id = idx;
      end
    end
  endfunction

  task automatic compare(input string tag);
    bit v; int id;
    modelSel(v, id);
    checks++;
    if (selValid !== v || (v && selId !== id[1:0])) begin
      errors++;
      $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
               tag, selValid, selId, v, id);
    end
  endtask

  task automatic expectSel(input bit v, input int id, input string tag);
    checks++;
    if (selValid !== v || (v && selId !== id[1:0])) begin
      errors++;
      $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
               tag, selValid, selId, v, id);
    end
  endtask

  // Drive one cycle of inputs at a falling edge, advance the model across
  // the following rising edge, then compare at the next falling edge.
  task automatic step(input logic [NT-1:0] ms, input logic [NT-1:0] fd,
                      input logic lg, input string tag);
    bit v; int id;
    missSet = ms; fillDone = fd; selLong = lg;
    modelSel(v, id);
    for (int t = 0; t < NT; t++) begin
      if (v && lg && id == t) mCnt[t] = SH;
      else if (mCnt[t] > 0)   mCnt[t] = mCnt[t] - 1;
      if (ms[t])      mMiss[t] = 1;
      else if (fd[t]) mMiss[t] = 0;
    end
    if (v) mLast = id;
    @(negedge clk);
    missSet = '0; fillDone = '0; selLong = 1'b0;
    compare(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: got running, expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rstN = 1'b0; missSet = '0; fillDone = '0; selLong = 1'b0;
    for (int t = 0; t < NT; t++) begin mCnt[t] = 0; mMiss[t] = 0; end
    mLast = NT - 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    expectSel(1, 0, "R1 reset selection");

    // R2: plain rotation
    step('0, '0, 0, "R2"); expectSel(1, 1, "R2 rotation");
    step('0, '0, 0, "R2"); expectSel(1, 2, "R2 rotation");
    step('0, '0, 0, "R2"); expectSel(1, 3, "R2 rotation");
    step('0, '0, 0, "R2"); expectSel(1, 0, "R2 wrap");

    // R3: thread 1 misses while thread 0 issues
    step(4'b0010, '0, 0, "R3"); expectSel(1, 2, "R3 skip missed");
    step('0, '0, 0, "R3");      expectSel(1, 3, "R3");
    step('0, '0, 0, "R3");      expectSel(1, 0, "R3");
    step('0, '0, 0, "R3");      expectSel(1, 2, "R3 still skipped");

    // R7: fill returns thread 1
    step('0, 4'b0010, 0, "R7"); expectSel(1, 3, "R7");
    step('0, '0, 0, "R7");      expectSel(1, 0, "R7");
    step('0, '0, 0, "R7");      expectSel(1, 1, "R7 thread back");

    // R8: miss and fill together on thread 0
    step(4'b0001, 4'b0001, 0, "R8"); expectSel(1, 2, "R8");
    step('0, '0, 0, "R8");           expectSel(1, 3, "R8");
    step('0, '0, 0, "R8");           expectSel(1, 1, "R8 miss wins");
    step('0, 4'b0001, 0, "R8");

    // R6: only thread 3 left ready
    step(4'b0111, '0, 0, "R6");
    step('0, '0, 0, "R6"); expectSel(1, 3, "R6 sole thread");
    step('0, '0, 0, "R6"); expectSel(1, 3, "R6 repeats");

    // R4: long op on thread 3 hides it for exactly SH cycles
    step('0, '0, 1, "R4"); expectSel(0, 0, "R4 shadow 1");
    step('0, '0, 0, "R4"); expectSel(0, 0, "R4 shadow 2");
    step('0, '0, 0, "R4"); expectSel(0, 0, "R4 shadow 3");
    step('0, '0, 0, "R4"); expectSel(1, 3, "R4 eligible again");

    // R5/R9: all missed, selLong while idle has no effect
    step(4'b1000, '0, 0, "R5"); expectSel(0, 0, "R5 all stalled");
    step('0, '0, 1, "R9");      expectSel(0, 0, "R9 idle");
    step('0, 4'b1111, 0, "R9"); expectSel(1, 0, "R9 no shadow from idle selLong");

    // Pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic [NT-1:0] ms, fd;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ms = (lfsr[15:13] == 3'd0) ? (NT'(1) << lfsr[1:0]) : '0;
      fd = lfsr[7:4] & {NT{lfsr[8]}};
      step(ms, fd, lfsr[9], "R2 R3 R4 R5 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule